// File: doc/BRIEF.md
# Rank-Aware Open-Row-First Request Picker

This block picks the next memory request to service from a small queue. Each queue slot carries a valid bit, a rank number, a bank number and a row address. Alongside the queue the picker receives the open-row state of every bank in every rank and a per-rank availability flag; a rank that is busy refreshing is unavailable. It also receives the rank used by the previous data burst, a flag saying whether the read/write direction has just changed, and a mask of banks that could be prepared soonest.

The picker favours row-buffer hits. A hit to the same rank as the last burst comes first. When the direction has just flipped, any hit counts as preferred. A hit to another rank is the next choice. If there is no hit at all, the picker falls back to the oldest entry whose bank is in the earliest-prepare mask. Entries aimed at an unavailable rank are never picked. When nothing can be picked, the found flag drops so that the surrounding controller stalls. In that case the index output keeps the last index that was picked.

Selection is combinational within the cycle. The only state is the register that holds the index. Queue depth and the widths of the rank, bank and row fields are parameters.

Top module: `rfPicker`

## Requirements
- R1: A slot is eligible only if its valid bit is 1 and its rank's bit in `rankAvail` is 1. The picker never reports found with an index that points at a slot that is not eligible.
- R2: When exactly one slot is valid, `pickFound` is 1 if and only if that slot's rank is available, and `pickIdx` is that slot's index. Row-hit state and the earliest-prepare mask play no part in this case.
- R3: With two or more valid slots, the lowest-indexed eligible slot that hits is picked first, where a hit counts only if its rank equals `lastRank` or `dirSwitched` is 1.
- R4: If no slot qualifies under R3, the lowest-indexed eligible slot that hits in any rank is picked.
- R5: If no eligible slot hits, the lowest-indexed eligible slot whose flattened bank id is set in `earlyMask` is picked. The flattened bank id is rank × 2^BANK_W + bank, and it is the bit position in `earlyMask` and `openValid`.
- R6: If no slot qualifies under R2 to R5, `pickFound` is 0.
- R7: When every bit of `rankAvail` is 0, `pickFound` is 0 whatever the queue holds.
- R8: While `pickFound` is 0, `pickIdx` shows the index from the most recent cycle in which `pickFound` was 1. After reset it shows 0.
- R9: A slot hits when `openValid` is 1 at its flattened bank id and the row stored at that id in `openRow` (field id × ROW_W) equals the slot's row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| entValid | input | N | Valid bit per queue slot; slot 0 is the oldest |
| entRank | input | N*RANK_W | Rank field per slot, slot i at bits i*RANK_W |
| entBank | input | N*BANK_W | Bank field per slot |
| entRow | input | N*ROW_W | Row field per slot |
| openValid | input | 2^(RANK_W+BANK_W) | Per flattened bank: a row is open |
| openRow | input | 2^(RANK_W+BANK_W)*ROW_W | Per flattened bank: the open row |
| rankAvail | input | 2^RANK_W | Per rank: 1 = available, 0 = refreshing |
| lastRank | input | RANK_W | Rank of the previous burst |
| dirSwitched | input | 1 | Read/write direction has just changed |
| earlyMask | input | 2^(RANK_W+BANK_W) | Banks that can be prepared earliest |
| pickFound | output | 1 | A slot was selected this cycle |
| pickIdx | output | clog2(N) | Index of the selected slot, held while not found |

## Verification
The assertions check four things on every cycle. A found index always points at a valid slot in an available rank. Found is low when no rank is available or when the queue is empty. A lone valid slot in an available rank is always found. The index does not move while found is low. The strict priority among preferred hits, other-rank hits and earliest-mask slots cannot be seen from a single cycle's implication. Only the bench scenarios show it, by comparing each pick with an independently computed choice across a dense sweep of queue contents, open rows, availability and direction. The same applies to the single-slot exemption from hit and mask rules.

// File: rtl/rfPickPkg.sv
package rfPickPkg;

  // strobes from control to datapath: which candidate class drives the index
  typedef struct packed {
    logic loadIdx;
    logic takeSingle;
    logic takePref;
    logic takeOther;
    logic takeEarly;
  } pickStrobeT;

  // summary flags from datapath to control
  typedef struct packed {
    logic singleMode;
    logic soleAvail;
    logic anyPref;
    logic anyOther;
    logic anyEarly;
  } pickStatusT;

endpackage

// File: rtl/rfPickDatapath.sv
module rfPickDatapath
  import rfPickPkg::*;
#(
  parameter int N      = 8,
  parameter int RANK_W = 1,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [N-1:0]                           entValid,
  input  logic [N*RANK_W-1:0]                    entRank,
  input  logic [N*BANK_W-1:0]                    entBank,
  input  logic [N*ROW_W-1:0]                     entRow,
  input  logic [(1<<(RANK_W+BANK_W))-1:0]        openValid,
  input  logic [(1<<(RANK_W+BANK_W))*ROW_W-1:0]  openRow,
  input  logic [(1<<RANK_W)-1:0]                 rankAvail,
  input  logic [RANK_W-1:0]                      lastRank,
  input  logic                                   dirSwitched,
  input  logic [(1<<(RANK_W+BANK_W))-1:0]        earlyMask,
  input  pickStrobeT                             strobe,
  output pickStatusT                             status,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0]   pickIdx
);

  localparam int IW    = (N > 1) ? $clog2(N) : 1;
  localparam int BID_W = RANK_W + BANK_W;
  localparam int NBID  = 1 << BID_W;

  // per-bank open row, unpacked for indexing by flattened id
  logic [ROW_W-1:0] rowOfBank [NBID];
  for (genvar b = 0; b < NBID; b++) begin : g_bank
    assign rowOfBank[b] = openRow[b*ROW_W +: ROW_W];
  end

  logic [N-1:0] eligible;
  logic [N-1:0] prefHit;
  logic [N-1:0] otherHit;
  logic [N-1:0] earlyOk;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [RANK_W-1:0] rk;
    logic [BANK_W-1:0] bk;
    logic [ROW_W-1:0]  rw;
    logic [BID_W-1:0]  bid;
    logic              isHit;
    assign rk  = entRank[i*RANK_W +: RANK_W];
    assign bk  = entBank[i*BANK_W +: BANK_W];
    assign rw  = entRow[i*ROW_W +: ROW_W];
    // concatenation equals rank * banks-per-rank + bank (power-of-two banks)
    assign bid = {rk, bk};
    assign isHit       = openValid[bid] && (rowOfBank[bid] == rw);
    assign eligible[i] = entValid[i] && rankAvail[rk];
    assign prefHit[i]  = eligible[i] && isHit && ((rk == lastRank) || dirSwitched);
    assign otherHit[i] = eligible[i] && isHit;
    assign earlyOk[i]  = eligible[i] && earlyMask[bid];
  end

  function automatic logic [IW-1:0] firstSet(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (v[k]) r = IW'(k);
    end
    return r;
  endfunction

  logic [IW-1:0] soleIdx, prefIdx, otherIdx, earlyIdx;
  assign soleIdx  = firstSet(entValid);
  assign prefIdx  = firstSet(prefHit);
  assign otherIdx = firstSet(otherHit);
  assign earlyIdx = firstSet(earlyOk);

  assign status.singleMode = ($countones(entValid) == 1);
  assign status.soleAvail  = eligible[soleIdx];
  assign status.anyPref    = |prefHit;
  assign status.anyOther   = |otherHit;
  assign status.anyEarly   = |earlyOk;

  logic [IW-1:0] chosenIdx;
  always_comb begin
    chosenIdx = '0;
    unique case (1'b1)
      strobe.takeSingle: chosenIdx = soleIdx;
      strobe.takePref:   chosenIdx = prefIdx;
      strobe.takeOther:  chosenIdx = otherIdx;
      strobe.takeEarly:  chosenIdx = earlyIdx;
      default:           chosenIdx = '0;
    endcase
  end

  logic [IW-1:0] heldIdx;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldIdx <= '0;
    end else if (strobe.loadIdx) begin
      heldIdx <= chosenIdx;
    end
  end

  assign pickIdx = strobe.loadIdx ? chosenIdx : heldIdx;

endmodule

// File: rtl/rfPickControl.sv
module rfPickControl
  import rfPickPkg::*;
(
  input  pickStatusT status,
  output pickStrobeT strobe,
  output logic       pickFound
);

  always_comb begin
    strobe = '0;
    if (status.singleMode) begin
      strobe.takeSingle = status.soleAvail;
    end else if (status.anyPref) begin
      strobe.takePref = 1'b1;
    end else if (status.anyOther) begin
      strobe.takeOther = 1'b1;
    end else if (status.anyEarly) begin
      strobe.takeEarly = 1'b1;
    end
    strobe.loadIdx = strobe.takeSingle | strobe.takePref |
                     strobe.takeOther  | strobe.takeEarly;
  end

  assign pickFound = strobe.loadIdx;

endmodule

// File: rtl/rfPicker.sv
module rfPicker
  import rfPickPkg::*;
#(
  parameter int N      = 8,
  parameter int RANK_W = 1,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [N-1:0]                           entValid,
  input  logic [N*RANK_W-1:0]                    entRank,
  input  logic [N*BANK_W-1:0]                    entBank,
  input  logic [N*ROW_W-1:0]                     entRow,
  input  logic [(1<<(RANK_W+BANK_W))-1:0]        openValid,
  input  logic [(1<<(RANK_W+BANK_W))*ROW_W-1:0]  openRow,
  input  logic [(1<<RANK_W)-1:0]                 rankAvail,
  input  logic [RANK_W-1:0]                      lastRank,
  input  logic                                   dirSwitched,
  input  logic [(1<<(RANK_W+BANK_W))-1:0]        earlyMask,
  output logic                                   pickFound,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0]   pickIdx
);

  pickStrobeT strobe;
  pickStatusT status;

  rfPickDatapath #(
    .N(N), .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .entValid(entValid), .entRank(entRank), .entBank(entBank), .entRow(entRow),
    .openValid(openValid), .openRow(openRow), .rankAvail(rankAvail),
    .lastRank(lastRank), .dirSwitched(dirSwitched), .earlyMask(earlyMask),
    .strobe(strobe), .status(status), .pickIdx(pickIdx)
  );

  rfPickControl u_ctl (
    .status(status), .strobe(strobe), .pickFound(pickFound)
  );

endmodule

// File: rtl/rfPickChecker.sv
module rfPickChecker #(
  parameter int N      = 8,
  parameter int RANK_W = 1,
  parameter int IW     = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [N-1:0]            entValid,
  input logic [N*RANK_W-1:0]     entRank,
  input logic [(1<<RANK_W)-1:0]  rankAvail,
  input logic                    pickFound,
  input logic [IW-1:0]           pickIdx
);

  logic [RANK_W-1:0] selRank;
  logic              selValid;
  logic              soleRankUp;
  always_comb begin
    selRank    = '0;
    selValid   = 1'b0;
    soleRankUp = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (IW'(i) == pickIdx) begin
        selRank  = entRank[i*RANK_W +: RANK_W];
        selValid = entValid[i];
      end
      if (entValid[i]) soleRankUp = rankAvail[entRank[i*RANK_W +: RANK_W]];
    end
  end

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R1: a found pick is a valid slot in an available rank
  p_eligible_r1: assert property (@(posedge clk) disable iff (!rstN)
    pickFound |-> (selValid && rankAvail[selRank]));

  // R2: a lone valid slot in an available rank is found
  p_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    (($countones(entValid) == 1) && soleRankUp) |-> pickFound);

  // R6: empty queue never yields a pick
  p_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    (entValid == '0) |-> !pickFound);

  // R7: all ranks refreshing stalls the picker
  p_all_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rankAvail == '0) |-> !pickFound);

  // R8: index stays put while nothing is found
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !pickFound) |-> (pickIdx == $past(pickIdx)));

endmodule

bind rfPicker rfPickChecker #(
  .N(N), .RANK_W(RANK_W), .IW((N > 1) ? $clog2(N) : 1)
) u_chk (
  .clk(clk), .rstN(rstN), .entValid(entValid), .entRank(entRank),
  .rankAvail(rankAvail), .pickFound(pickFound), .pickIdx(pickIdx)
);

// File: tb/rfPicker_test.sv
module rfPicker_test;

  localparam int N      = 4;
  localparam int RANK_W = 1;
  localparam int BANK_W = 1;
  localparam int ROW_W  = 2;
  localparam int IW     = 2;
  localparam int BANKS  = 1 << BANK_W;
  localparam int NBID   = 1 << (RANK_W + BANK_W);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0]            entValid = '0;
  logic [N*RANK_W-1:0]     entRank  = '0;
  logic [N*BANK_W-1:0]     entBank  = '0;
  logic [N*ROW_W-1:0]      entRow   = '0;
  logic [NBID-1:0]         openValid = '0;
  logic [NBID*ROW_W-1:0]   openRow  = '0;
  logic [(1<<RANK_W)-1:0]  rankAvail = '0;
  logic [RANK_W-1:0]       lastRank = '0;
  logic                    dirSwitched = 1'b0;
  logic [NBID-1:0]         earlyMask = '0;
  logic                    pickFound;
  logic [IW-1:0]           pickIdx;

  int checks = 0;
  int errors = 0;
  int expHeld = 0;

  always #5 clk = ~clk;

  rfPicker #(.N(N), .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) uut (
    .clk(clk), .rstN(rstN), .entValid(entValid), .entRank(entRank),
    .entBank(entBank), .entRow(entRow), .openValid(openValid), .openRow(openRow),
    .rankAvail(rankAvail), .lastRank(lastRank), .dirSwitched(dirSwitched),
    .earlyMask(earlyMask), .pickFound(pickFound), .pickIdx(pickIdx)
  );

  function automatic int rankOf(int i);  return int'(entRank[i*RANK_W +: RANK_W]); endfunction
  function automatic int bidOf(int i);   return rankOf(i) * BANKS + int'(entBank[i*BANK_W +: BANK_W]); endfunction
  function automatic bit eligOf(int i);  return entValid[i] && rankAvail[rankOf(i)]; endfunction
  // R9: hit = open flag set and stored row equal
  function automatic bit hitOf(int i);
    return openValid[bidOf(i)] && (openRow[bidOf(i)*ROW_W +: ROW_W] == entRow[i*ROW_W +: ROW_W]);
  endfunction

  task automatic model(output bit f, output int idx, output string tag);
    int cnt;
    cnt = 0; f = 0; idx = expHeld; tag = "R6";
    for (int i = 0; i < N; i++) if (entValid[i]) cnt++;
    if (rankAvail == '0) tag = "R7";
    if (cnt == 1) begin
      tag = "R2";
      for (int i = 0; i < N; i++) if (entValid[i]) begin f = eligOf(i); if (f) idx = i; end
      return;
    end
    for (int i = 0; i < N; i++)
      if (!f && eligOf(i) && hitOf(i) && (rankOf(i) == int'(lastRank) || dirSwitched)) begin
        f = 1; idx = i; tag = "R3 R9";
      end
    if (f) return;
    for (int i = 0; i < N; i++)
      if (!f && eligOf(i) && hitOf(i)) begin f = 1; idx = i; tag = "R4 R9"; end
    if (f) return;
    for (int i = 0; i < N; i++)
      if (!f && eligOf(i) && earlyMask[bidOf(i)]) begin f = 1; idx = i; tag = "R5"; end
  endtask

  task automatic checkNow(string note);
    bit f; int idx; string tag;
    model(f, idx, tag);
    #2;
    checks++;
    if (pickFound !== f || int'(pickIdx) != idx) begin
      errors++;
      $display("FAIL %s %s: found=%0b idx=%0d expected found=%0b idx=%0d",
               tag, note, pickFound, pickIdx, f, idx);
    end
    if (pickFound === 1'b1) begin
      checks++;
      if (!eligOf(int'(pickIdx))) begin
        errors++;
        $display("FAIL R1 %s: picked idx=%0d is ineligible, expected an eligible slot", note, pickIdx);
      end
    end
    if (!f) begin
      checks++; // R8 hold
      if (int'(pickIdx) != expHeld) begin
        errors++;
        $display("FAIL R8 %s: idx=%0d expected held %0d", note, pickIdx, expHeld);
      end
    end
    @(posedge clk);
    if (f) expHeld = idx;
    @(negedge clk);
  endtask

  task automatic setEnt(int i, bit v, int r, int b, int row);
    entValid[i] = v;
    entRank[i*RANK_W +: RANK_W] = RANK_W'(r);
    entBank[i*BANK_W +: BANK_W] = BANK_W'(b);
    entRow[i*ROW_W +: ROW_W]    = ROW_W'(row);
  endtask

  task automatic setOpen(int r, int b, bit v, int row);
    openValid[r*BANKS + b] = v;
    openRow[(r*BANKS + b)*ROW_W +: ROW_W] = ROW_W'(row);
  endtask

  task automatic clearAll();
    entValid = '0; entRank = '0; entBank = '0; entRow = '0;
    openValid = '0; openRow = '0; earlyMask = '0;
    rankAvail = '1; lastRank = '0; dirSwitched = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clearAll();
    rankAvail = '0;
    repeat (3) @(negedge clk);
    checks++; // reset state, R8
    if (pickFound !== 1'b0 || pickIdx !== '0) begin
      errors++;
      $display("FAIL R8 reset: found=%0b idx=%0d expected 0 0", pickFound, pickIdx);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R2: lone slot, no hit and no mask, still found
    clearAll(); setEnt(2, 1, 1, 0, 3);
    checkNow("single available");
    // R2: lone slot to refreshing rank
    rankAvail = 2'b01;
    checkNow("single busy rank");
    // R7: all ranks refreshing with hits present
    clearAll(); rankAvail = '0;
    setOpen(0, 0, 1, 1); setEnt(0, 1, 0, 0, 1); setEnt(1, 1, 0, 0, 1);
    checkNow("all busy");
    // R3 versus R4
    clearAll(); lastRank = 1'b1;
    setOpen(0, 1, 1, 2); setOpen(1, 0, 1, 3);
    setEnt(0, 1, 0, 1, 2); setEnt(1, 1, 1, 0, 3);
    checkNow("same rank hit beats older other-rank hit");
    dirSwitched = 1'b1;
    checkNow("direction switch makes oldest hit win");
    // R4 over R5
    clearAll(); lastRank = 1'b1; earlyMask = 4'b1111;
    setOpen(0, 0, 1, 1);
    setEnt(0, 1, 1, 1, 0); setEnt(1, 1, 0, 0, 1);
    checkNow("other-rank hit beats mask");
    // R5 with flattened id 3 (rank 1 bank 1)
    clearAll(); earlyMask = 4'b1000;
    setEnt(0, 1, 0, 1, 0); setEnt(1, 1, 1, 0, 0); setEnt(2, 1, 1, 1, 0);
    checkNow("earliest mask");
    // R9: open row mismatch is no hit; R6 nothing qualifies
    clearAll(); setOpen(0, 0, 1, 2);
    setEnt(0, 1, 0, 0, 1); setEnt(3, 1, 0, 0, 3);
    checkNow("row mismatch nothing found");
    // R1: invalid slot with matching row ignored
    clearAll(); setOpen(0, 0, 1, 1); earlyMask = 4'b0001;
    setEnt(0, 0, 0, 0, 1); setEnt(1, 1, 1, 1, 0); setEnt(2, 1, 0, 0, 0);
    checkNow("invalid slot ignored");
    // R1: refreshing rank hit skipped in favour of mask
    clearAll(); rankAvail = 2'b01; earlyMask = 4'b0001;
    setOpen(1, 0, 1, 1);
    setEnt(0, 1, 1, 0, 1); setEnt(1, 1, 0, 0, 2);
    checkNow("refreshing hit skipped");

    // dense sweep
    for (int n = 0; n < 6000; n++) begin
      entValid  = N'($urandom);
      entRank   = (N*RANK_W)'($urandom);
      entBank   = (N*BANK_W)'($urandom);
      entRow    = (N*ROW_W)'($urandom);
      openValid = NBID'($urandom);
      openRow   = (NBID*ROW_W)'($urandom);
      rankAvail = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
      lastRank  = RANK_W'($urandom);
      dirSwitched = 1'($urandom);
      earlyMask = NBID'($urandom);
      checkNow("sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule